// File: doc/BRIEF.md
# Looped Container Virtual-Circuit Endpoint

This block is one end of a guaranteed-bandwidth virtual circuit that runs over a deflection-routed mesh. A single high-priority container circulates on a fixed closed route between a source endpoint and a destination endpoint. Because the container has priority over best-effort traffic, it is never deflected off its route. Its round trip is therefore fixed, and each endpoint gets one container visit per loop.

The same module serves both roles, chosen by the `IS_SRC` parameter. A source fills a passing empty container with the oldest word from its local FIFO. A destination empties a passing full container into its local FIFO, and the container continues back toward the source empty. Both roles act only on containers whose circuit ID equals `VCID`. Every other container passes through unchanged.

A free-running slot counter, modulo `NSLOT`, selects which of the temporally disjoint logical networks a packet joins when it enters. After reset, a source injects exactly one empty container, on its assigned slot `SLOT`. The route itself and the mesh switch are outside this block.

Top module: `lc_vc_endpoint`

## Requirements
- R1: While reset is held and on the first cycle after its release, `out_valid` is 0 and `slot_q` is 0. A source shows `tx_ready`=1 and a destination shows `rx_valid`=0.
- R2: `slot_q` advances by one every cycle and returns to 0 after reaching `NSLOT-1`.
- R3: A source emits exactly one self-created container after reset. It has `out_full`=0 and `out_vcid`=`VCID`, and `out_valid` rises on the first cycle in which `slot_q` equals (`SLOT`+1) mod `NSLOT`. A destination never creates a container.
- R4: When a source receives a matching empty container and its FIFO holds data, the next cycle shows `out_full`=1 with the oldest queued word. Words leave in the order they were pushed.
- R5: When a source receives a matching empty container and its FIFO is empty, the container leaves empty. It is neither dropped nor held.
- R6: A source forwards a matching full container with its data unchanged. The queued word stays for a later visit.
- R7: When a destination receives a matching full container and its FIFO has room, the word appears on `rx_data`/`rx_valid`. The container leaves with `out_full`=0 and the same circuit ID.
- R8: When a destination's FIFO is full, a matching full container leaves still full with its data. It is not unloaded.
- R9: A container whose ID differs from `VCID` is forwarded with flag, ID and data unchanged, in either role.
- R10: Each valid input container appears on the output exactly one cycle later.
- R11: A source lowers `tx_ready` when its FIFO holds `DEPTH` words. A word offered while `tx_ready` is 0 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Container arriving on the route |
| in_full | input | 1 | Arriving container holds a word |
| in_vcid | input | IDW | Arriving container circuit ID |
| in_data | input | DW | Arriving container payload |
| out_valid | output | 1 | Container leaving on the route |
| out_full | output | 1 | Leaving container holds a word |
| out_vcid | output | IDW | Leaving container circuit ID |
| out_data | output | DW | Leaving container payload |
| slot_q | output | SW | Current entry slot index |
| tx_valid | input | 1 | Source: word offered for sending |
| tx_data | input | DW | Source: offered word |
| tx_ready | output | 1 | Source: FIFO can take a word |
| rx_valid | output | 1 | Destination: a received word is waiting |
| rx_data | output | DW | Destination: oldest received word |
| rx_ready | input | 1 | Destination: consume the waiting word |

## Verification
A container's result shows on the output one edge after it is presented. The bench therefore drives each container at a falling edge and reads the output at the next falling edge. A pushed word reaches the FIFO at the next rising edge. A received word is visible on `rx_data` at the falling edge that follows the unloading edge, and a pop reveals the next word one edge after `rx_ready`. The self-created container is expected one cycle after `slot_q` equals `SLOT`. The bench predicts that cycle from the slot value it observed at the previous falling edge.

// File: rtl/lc_vc_endpoint.sv
module lc_vc_endpoint #(
  parameter int NSLOT  = 4,
  parameter int SLOT   = 2,
  parameter int IS_SRC = 1,
  parameter int IDW    = 4,
  parameter int VCID   = 5,
  parameter int DW     = 16,
  parameter int DEPTH  = 4,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_full,
  input  logic [IDW-1:0] in_vcid,
  input  logic [DW-1:0]  in_data,
  output logic           out_valid,
  output logic           out_full,
  output logic [IDW-1:0] out_vcid,
  output logic [DW-1:0]  out_data,
  output logic [SW-1:0]  slot_q,
  input  logic           tx_valid,
  input  logic [DW-1:0]  tx_data,
  output logic           tx_ready,
  output logic           rx_valid,
  output logic [DW-1:0]  rx_data,
  input  logic           rx_ready
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_p, rd_p;
  logic [AW:0]   cnt;
  logic          push, pop, load, unload, boot_q, boot_go;
  logic [DW-1:0] wdata;

  wire fifo_empty = (cnt == '0);
  wire fifo_full  = (cnt == (AW+1)'(DEPTH));
  wire hit        = in_valid && (in_vcid == IDW'(VCID));
  wire slot_hit   = (slot_q == SW'(SLOT));

  generate
    if (IS_SRC != 0) begin : g_src
      assign load     = hit && !in_full && !fifo_empty;
      assign unload   = 1'b0;
      assign push     = tx_valid && !fifo_full;
      assign pop      = load;
      assign wdata    = tx_data;
      assign tx_ready = !fifo_full;
      assign rx_valid = 1'b0;
      assign rx_data  = '0;
    end else begin : g_dst
      assign load     = 1'b0;
      assign unload   = hit && in_full && !fifo_full;
      assign push     = unload;
      assign pop      = rx_ready && !fifo_empty;
      assign wdata    = in_data;
      assign tx_ready = 1'b0;
      assign rx_valid = !fifo_empty;
      assign rx_data  = mem[rd_p];
    end
  endgenerate

  assign boot_go = boot_q && slot_hit && !in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      boot_q <= (IS_SRC != 0);
    end else begin
      slot_q <= (slot_q == SW'(NSLOT-1)) ? '0 : slot_q + 1'b1;
      if (boot_go) boot_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= (wr_p == AW'(DEPTH-1)) ? '0 : wr_p + 1'b1;
      if (pop)  rd_p <= (rd_p == AW'(DEPTH-1)) ? '0 : rd_p + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_full  <= 1'b0;
      out_vcid  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid || boot_go;
      if (in_valid) begin
        out_full <= (in_full && !unload) || load;
        out_vcid <= in_vcid;
        out_data <= load ? mem[rd_p] : in_data;
      end else if (boot_go) begin
        out_full <= 1'b0;
        out_vcid <= IDW'(VCID);
        out_data <= '0;
      end else begin
        out_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lc_vc_endpoint_chk.sv
module lc_vc_endpoint_chk #(
  parameter int NSLOT  = 4,
  parameter int SLOT   = 2,
  parameter int IS_SRC = 1,
  parameter int IDW    = 4,
  parameter int VCID   = 5,
  parameter int DW     = 16,
  parameter int DEPTH  = 4,
  parameter int SW     = 2,
  parameter int AW     = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_full,
  input logic [IDW-1:0] in_vcid,
  input logic [DW-1:0]  in_data,
  input logic           out_valid,
  input logic           out_full,
  input logic [IDW-1:0] out_vcid,
  input logic [DW-1:0]  out_data,
  input logic [SW-1:0]  slot_q,
  input logic [AW:0]    cnt
);
  logic       prev_in;
  logic [1:0] boots;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_in <= 1'b0;
      boots   <= '0;
    end else begin
      prev_in <= in_valid;
      if (out_valid && !prev_in && boots != 2'd3) boots <= boots + 2'd1;
    end
  end

  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SW'(NSLOT-1)) |=> (slot_q == '0));
  a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != SW'(NSLOT-1)) |=> (slot_q == SW'($past(slot_q) + 1'b1)));
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_vcid != IDW'(VCID)) |=>
      (out_full == $past(in_full) && out_vcid == $past(in_vcid) && out_data == $past(in_data)));
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_SRC != 0 && in_valid && in_full) |=> (out_full && out_data == $past(in_data)));
  a_r8_dst_never_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_SRC == 0 && in_valid && !in_full) |=> !out_full);
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  a_r3_single_boot: assert property (@(posedge clk) disable iff (!rst_n)
    boots <= ((IS_SRC != 0) ? 2'd1 : 2'd0));
endmodule

bind lc_vc_endpoint lc_vc_endpoint_chk #(
  .NSLOT(NSLOT), .SLOT(SLOT), .IS_SRC(IS_SRC), .IDW(IDW), .VCID(VCID),
  .DW(DW), .DEPTH(DEPTH), .SW(SW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_full(in_full),
  .in_vcid(in_vcid), .in_data(in_data), .out_valid(out_valid),
  .out_full(out_full), .out_vcid(out_vcid), .out_data(out_data),
  .slot_q(slot_q), .cnt(cnt)
);

// File: tb/sim_lc_vc_endpoint.sv
module sim_lc_vc_endpoint;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  logic        s_iv = 0, s_if = 0;
  logic [3:0]  s_id = 0;
  logic [15:0] s_id_data = 0;
  logic        s_ov, s_of, s_txr, s_rxv;
  logic [3:0]  s_oid;
  logic [15:0] s_od, s_rxd;
  logic [1:0]  s_slot;
  logic        s_txv = 0;
  logic [15:0] s_txd = 0;

  logic        d_iv = 0, d_if = 0;
  logic [3:0]  d_id = 0;
  logic [15:0] d_id_data = 0;
  logic        d_ov, d_of, d_txr, d_rxv;
  logic [3:0]  d_oid;
  logic [15:0] d_od, d_rxd;
  logic [1:0]  d_slot;
  logic        d_rxr = 0;

  lc_vc_endpoint #(.NSLOT(4), .SLOT(2), .IS_SRC(1), .IDW(4), .VCID(5), .DW(16), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_full(s_if), .in_vcid(s_id), .in_data(s_id_data),
    .out_valid(s_ov), .out_full(s_of), .out_vcid(s_oid), .out_data(s_od), .slot_q(s_slot),
    .tx_valid(s_txv), .tx_data(s_txd), .tx_ready(s_txr), .rx_valid(s_rxv), .rx_data(s_rxd),
    .rx_ready(1'b0));

  lc_vc_endpoint #(.NSLOT(4), .SLOT(1), .IS_SRC(0), .IDW(4), .VCID(5), .DW(16), .DEPTH(2)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(d_iv), .in_full(d_if), .in_vcid(d_id), .in_data(d_id_data),
    .out_valid(d_ov), .out_full(d_of), .out_vcid(d_oid), .out_data(d_od), .slot_q(d_slot),
    .tx_valid(1'b0), .tx_data(16'h0), .tx_ready(d_txr), .rx_valid(d_rxv), .rx_data(d_rxd),
    .rx_ready(d_rxr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic src_send(input logic full, input logic [3:0] id, input logic [15:0] data,
                          input logic ef, input logic [15:0] ed, input string req);
    s_iv = 1; s_if = full; s_id = id; s_id_data = data;
    @(negedge clk);
    s_iv = 0; s_if = 0;
    chk({req, " valid"}, s_ov, 1);
    chk({req, " full"}, s_of, ef);
    chk({req, " id"}, s_oid, id);
    if (ef) chk({req, " data"}, s_od, ed);
  endtask

  task automatic src_push(input logic [15:0] data);
    s_txv = 1; s_txd = data;
    @(negedge clk);
    s_txv = 0;
  endtask

  task automatic dst_send(input logic full, input logic [3:0] id, input logic [15:0] data,
                          input logic ef, input string req);
    d_iv = 1; d_if = full; d_id = id; d_id_data = data;
    @(negedge clk);
    d_iv = 0; d_if = 0;
    chk({req, " valid"}, d_ov, 1);
    chk({req, " full"}, d_of, ef);
    chk({req, " id"}, d_oid, id);
    if (ef) chk({req, " data"}, d_od, data);
  endtask

  task automatic dst_pop();
    d_rxr = 1;
    @(negedge clk);
    d_rxr = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    chk("R1 ov in reset", s_ov, 0);
    @(negedge clk);
    rst_n = 1;
    chk("R1 src ov", s_ov, 0);
    chk("R1 slot", s_slot, 0);
    chk("R1 tx_ready", s_txr, 1);
    chk("R1 dst rx_valid", d_rxv, 0);
    chk("R1 dst ov", d_ov, 0);
  endtask

  task automatic t_boot();
    logic seen = 0;
    int prev = s_slot;
    for (int i = 0; i < 12; i++) begin
      logic exp_v;
      @(negedge clk);
      exp_v = (prev == 2) && !seen;
      chk("R3 boot valid", s_ov, exp_v);
      chk("R3 dst no boot", d_ov, 0);
      chk("R2 slot step", s_slot, (prev + 1) % 4);
      if (exp_v) begin
        chk("R3 boot empty", s_of, 0);
        chk("R3 boot id", s_oid, 5);
        seen = 1;
      end
      prev = s_slot;
    end
    chk("R3 boot seen", seen, 1);
  endtask

  task automatic t_src_load();
    src_push(16'hA001);
    src_push(16'hA002);
    src_send(0, 5, 16'h0, 1, 16'hA001, "R4 first word");
    src_send(0, 5, 16'h0, 1, 16'hA002, "R4 second word");
    src_send(0, 5, 16'h0, 0, 16'h0, "R5 empty fifo");
    @(negedge clk);
    chk("R10 idle no output", s_ov, 0);
  endtask

  task automatic t_src_full();
    src_push(16'hC0C0);
    src_send(1, 5, 16'hD00D, 1, 16'hD00D, "R6 full passes");
    src_send(0, 5, 16'h0, 1, 16'hC0C0, "R6 word kept");
  endtask

  task automatic t_foreign();
    src_push(16'hE0E0);
    src_send(0, 3, 16'h1234, 0, 16'h0, "R9 src foreign empty");
    chk("R9 src foreign data", s_od, 16'h1234);
    src_send(1, 7, 16'h5678, 1, 16'h5678, "R9 src foreign full");
    src_send(0, 5, 16'h0, 1, 16'hE0E0, "R9 word still queued");
  endtask

  task automatic t_txfull();
    for (int i = 0; i < 4; i++) src_push(16'hF000 + 16'(i));
    chk("R11 tx_ready low", s_txr, 0);
    src_push(16'hBAD0);
    for (int i = 0; i < 4; i++) src_send(0, 5, 16'h0, 1, 16'hF000 + 16'(i), "R11 drain order");
    src_send(0, 5, 16'h0, 0, 16'h0, "R11 extra word dropped");
    chk("R11 tx_ready back", s_txr, 1);
  endtask

  task automatic t_dst();
    dst_send(1, 5, 16'h1111, 0, "R7 unload first");
    chk("R7 rx_valid", d_rxv, 1);
    chk("R7 rx_data", d_rxd, 16'h1111);
    dst_send(1, 5, 16'h2222, 0, "R7 unload second");
    dst_send(1, 5, 16'h3333, 1, "R8 fifo full");
    dst_send(0, 5, 16'h0, 0, "R9 dst empty passes");
    dst_send(1, 2, 16'h4444, 1, "R9 dst foreign full");
    chk("R9 dst rx untouched", d_rxd, 16'h1111);
    dst_pop();
    chk("R7 second word", d_rxd, 16'h2222);
    dst_send(1, 5, 16'h3333, 0, "R8 retried unload");
    dst_pop();
    chk("R7 third word", d_rxd, 16'h3333);
    dst_pop();
    chk("R7 drained", d_rxv, 0);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_src_load();
    t_src_full();
    t_foreign();
    t_txfull();
    t_dst();
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule